// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of completed analog-to-digital conversion results. It raises a flag once one chosen channel has met a programmed threshold condition on a run of consecutive conversions. It contains two comparator units, and each has its own settings: an enable, the channel it watches (0 to 7), a condition bit (below the threshold, or at or above it), a 12-bit threshold and a required run length of 1 to 16. A conversion of the watched channel that meets the condition lengthens the run. One that fails the condition ends the run. Conversions of other channels are ignored.

Each unit's flag is sticky and is cleared by a write-one-to-clear pulse. A per-flag mask decides whether a set flag drives the shared interrupt request. A masked flag is still recorded. The conversion source, the register file and any data movement engine sit outside this block.

Top module: `adc_win_cmp`

## Requirements
- R1: After reset both flags and the interrupt request are 0.
- R2: With condition bit 1 a result passes when it is greater than or equal to the threshold. With condition bit 0 it passes when it is strictly less than the threshold. A result equal to the threshold passes only with condition bit 1.
- R3: The run-length field holds N-1, so field value 0 means N=1 and field value 15 means N=16. A flag sets on the N-th consecutive passing conversion of its channel and on no earlier one.
- R4: A conversion of the watched channel that fails the condition restarts that unit's run from zero.
- R5: Conversions of channels other than the watched one neither lengthen nor break the run.
- R6: A set flag stays at 1 until a clear pulse is given on its bit of `flag_clr_i`. If a set and a clear of the same flag occur in the same cycle, the set wins.
- R7: Once a run has reached N, the run count holds there. After a clear, the next passing conversion of the watched channel sets the flag again.
- R8: While a unit's enable is 0, its run is held at zero and it never sets its flag. Dropping the enable leaves an already set flag unchanged.
- R9: `irq_o` is 1 exactly when some flag is 1 whose bit of `irq_mask_i` is 0. A mask bit of 1 stops that flag from driving the interrupt but does not stop the flag from setting.
- R10: The two units count, set and clear independently of each other.
- R11: A flag becomes visible on `flag_o` in the cycle after the conversion strobe that completes the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_valid_i | input | 1 | One-cycle strobe: a conversion result is present |
| conv_ch_i | input | 3 | Channel number of the result |
| conv_data_i | input | 12 | Conversion result |
| cmp_en_i | input | 2 | Per-unit enable |
| cmp_ch_i | input | 6 | Watched channel, 3 bits per unit (unit 0 in bits 2:0) |
| cmp_ge_i | input | 2 | Per-unit condition: 1 = at or above, 0 = below |
| cmp_val_i | input | 24 | Threshold, 12 bits per unit (unit 0 in bits 11:0) |
| cmp_need_i | input | 8 | Run length minus one, 4 bits per unit (unit 0 in bits 3:0) |
| flag_clr_i | input | 2 | Write-one-to-clear pulse per flag |
| irq_mask_i | input | 2 | Per-flag interrupt mask, 1 = masked |
| flag_o | output | 2 | Sticky comparator flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Threshold-edge results (equal to the threshold, and one below it) show whether each condition encoding places the boundary correctly. Runs are interleaved with foreign-channel results and with single failing results, which separates a counter that restarts on a miss from one that ignores other channels. Runs of length 1 and 16 probe both ends of the length field. A clear issued alongside a new match, a disable in the middle of a run and mask changes while flags are set tell apart the orderings of set, clear and gating.

// File: rtl/adc_win_cmp_pkg.sv
package adc_win_cmp_pkg;
  localparam int unsigned AWC_NUM_CMP = 2;
  localparam int unsigned AWC_CH_W    = 3;
  localparam int unsigned AWC_DATA_W  = 12;
  localparam int unsigned AWC_NEED_W  = 4;

  typedef enum logic {
    COND_LT = 1'b0,
    COND_GE = 1'b1
  } cmp_cond_e;
endpackage

// File: rtl/awc_match.sv
module awc_match
  import adc_win_cmp_pkg::*;
#(
  parameter int unsigned CH_W   = AWC_CH_W,
  parameter int unsigned DATA_W = AWC_DATA_W
) (
  input  logic              valid_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CH_W-1:0]   sel_ch_i,
  input  cmp_cond_e         cond_i,
  input  logic [DATA_W-1:0] thr_i,
  output logic              hit_o,
  output logic              pass_o
);
  logic below;

  assign below = data_i < thr_i;
  assign hit_o = valid_i && (ch_i == sel_ch_i);

  always_comb begin
    unique case (cond_i)
      COND_GE: pass_o = ~below;
      default: pass_o = below;
    endcase
  end
endmodule

// File: rtl/awc_run_cnt.sv
module awc_run_cnt #(
  parameter int unsigned NEED_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hit_i,
  input  logic              pass_i,
  input  logic [NEED_W-1:0] need_m1_i,
  output logic              set_o
);
  localparam int unsigned RUN_W = NEED_W + 1;

  logic [RUN_W-1:0] run_q, run_d;
  logic [RUN_W-1:0] need_m1_x;
  logic             reached;

  assign need_m1_x = {1'b0, need_m1_i};
  // run_q counts prior passes; this pass completes the run when run_q >= N-1
  assign reached   = run_q >= need_m1_x;
  assign set_o     = en_i && hit_i && pass_i && reached;

  always_comb begin
    run_d = run_q;
    if (!en_i) begin
      run_d = '0;
    end else if (hit_i) begin
      if (!pass_i)              run_d = '0;
      else if (run_q <= need_m1_x) run_d = run_q + 1'b1;  // saturates at N
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end
endmodule

// File: rtl/awc_flag_bank.sv
module awc_flag_bank #(
  parameter int unsigned NUM = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  input  logic [NUM-1:0] mask_i,
  output logic [NUM-1:0] flag_o,
  output logic           irq_o
);
  logic [NUM-1:0] flag_q;

  for (genvar g = 0; g < NUM; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ~mask_i);
endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
  import adc_win_cmp_pkg::*;
#(
  parameter int unsigned NUM_CMP = AWC_NUM_CMP,
  parameter int unsigned CH_W    = AWC_CH_W,
  parameter int unsigned DATA_W  = AWC_DATA_W,
  parameter int unsigned NEED_W  = AWC_NEED_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      conv_valid_i,
  input  logic [CH_W-1:0]           conv_ch_i,
  input  logic [DATA_W-1:0]         conv_data_i,
  input  logic [NUM_CMP-1:0]        cmp_en_i,
  input  logic [NUM_CMP*CH_W-1:0]   cmp_ch_i,
  input  logic [NUM_CMP-1:0]        cmp_ge_i,
  input  logic [NUM_CMP*DATA_W-1:0] cmp_val_i,
  input  logic [NUM_CMP*NEED_W-1:0] cmp_need_i,
  input  logic [NUM_CMP-1:0]        flag_clr_i,
  input  logic [NUM_CMP-1:0]        irq_mask_i,
  output logic [NUM_CMP-1:0]        flag_o,
  output logic                      irq_o
);
  logic [NUM_CMP-1:0] hit, pass, set;

  for (genvar u = 0; u < NUM_CMP; u++) begin : g_unit
    cmp_cond_e cond;
    assign cond = cmp_cond_e'(cmp_ge_i[u]);

    awc_match #(
      .CH_W   (CH_W),
      .DATA_W (DATA_W)
    ) u_match (
      .valid_i  (conv_valid_i),
      .ch_i     (conv_ch_i),
      .data_i   (conv_data_i),
      .sel_ch_i (cmp_ch_i[u*CH_W +: CH_W]),
      .cond_i   (cond),
      .thr_i    (cmp_val_i[u*DATA_W +: DATA_W]),
      .hit_o    (hit[u]),
      .pass_o   (pass[u])
    );

    awc_run_cnt #(
      .NEED_W (NEED_W)
    ) u_run (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (cmp_en_i[u]),
      .hit_i     (hit[u]),
      .pass_i    (pass[u]),
      .need_m1_i (cmp_need_i[u*NEED_W +: NEED_W]),
      .set_o     (set[u])
    );
  end

  awc_flag_bank #(
    .NUM (NUM_CMP)
  ) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (flag_clr_i),
    .mask_i (irq_mask_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/adc_win_cmp_chk.sv
module adc_win_cmp_chk #(
  parameter int unsigned NUM_CMP = 2,
  parameter int unsigned CH_W    = 3,
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned NEED_W  = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      conv_valid_i,
  input logic [CH_W-1:0]           conv_ch_i,
  input logic [DATA_W-1:0]         conv_data_i,
  input logic [NUM_CMP-1:0]        cmp_en_i,
  input logic [NUM_CMP*CH_W-1:0]   cmp_ch_i,
  input logic [NUM_CMP-1:0]        cmp_ge_i,
  input logic [NUM_CMP*DATA_W-1:0] cmp_val_i,
  input logic [NUM_CMP*NEED_W-1:0] cmp_need_i,
  input logic [NUM_CMP-1:0]        flag_clr_i,
  input logic [NUM_CMP-1:0]        irq_mask_i,
  input logic [NUM_CMP-1:0]        flag_o,
  input logic                      irq_o
);
  for (genvar u = 0; u < NUM_CMP; u++) begin : g_chk
    logic sel_hit, ok;
    assign sel_hit = conv_valid_i && (conv_ch_i == cmp_ch_i[u*CH_W +: CH_W]);
    assign ok = cmp_ge_i[u] ? (conv_data_i >= cmp_val_i[u*DATA_W +: DATA_W])
                            : (conv_data_i <  cmp_val_i[u*DATA_W +: DATA_W]);

    // R8
    flag_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[u]) |-> $past(cmp_en_i[u] && sel_hit));

    // R6
    flag_fall_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[u]) |-> $past(flag_clr_i[u]));

    // R3
    single_run_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_en_i[u] && sel_hit && ok && cmp_need_i[u*NEED_W +: NEED_W] == '0)
      |=> flag_o[u]);
  end

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o == '0) |-> !irq_o);

  // R9
  irq_all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&irq_mask_i) |-> !irq_o);
endmodule

bind adc_win_cmp adc_win_cmp_chk #(
  .NUM_CMP (NUM_CMP),
  .CH_W    (CH_W),
  .DATA_W  (DATA_W),
  .NEED_W  (NEED_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_valid_i (conv_valid_i),
  .conv_ch_i    (conv_ch_i),
  .conv_data_i  (conv_data_i),
  .cmp_en_i     (cmp_en_i),
  .cmp_ch_i     (cmp_ch_i),
  .cmp_ge_i     (cmp_ge_i),
  .cmp_val_i    (cmp_val_i),
  .cmp_need_i   (cmp_need_i),
  .flag_clr_i   (flag_clr_i),
  .irq_mask_i   (irq_mask_i),
  .flag_o       (flag_o),
  .irq_o        (irq_o)
);

// File: tb/adc_win_cmp_test.sv
module adc_win_cmp_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        conv_valid_i = 1'b0;
  logic [2:0]  conv_ch_i = '0;
  logic [11:0] conv_data_i = '0;
  logic [1:0]  cmp_en_i = '0;
  logic [5:0]  cmp_ch_i = '0;
  logic [1:0]  cmp_ge_i = '0;
  logic [23:0] cmp_val_i = '0;
  logic [7:0]  cmp_need_i = '0;
  logic [1:0]  flag_clr_i = '0;
  logic [1:0]  irq_mask_i = '0;
  logic [1:0]  flag_o;
  logic        irq_o;

  adc_win_cmp uut (
    .clk_i, .rst_ni, .conv_valid_i, .conv_ch_i, .conv_data_i,
    .cmp_en_i, .cmp_ch_i, .cmp_ge_i, .cmp_val_i, .cmp_need_i,
    .flag_clr_i, .irq_mask_i, .flag_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;

  // pending configuration, applied at the next step
  logic [1:0]  n_en = '0, n_ge = '0, n_mask = '0;
  logic [2:0]  n_ch [2];
  logic [11:0] n_val [2];
  logic [3:0]  n_need [2];

  // reference model state
  int   m_run [2];
  logic [1:0] m_flag = '0;

  logic [2:0] exp_q [$];
  string      tag_q [$];

  task automatic step(input logic v, input logic [2:0] ch, input logic [11:0] d,
                      input logic [1:0] clr, input string tag);
    @(posedge clk_i); #1;
    cmp_en_i     = n_en;
    cmp_ge_i     = n_ge;
    irq_mask_i   = n_mask;
    cmp_ch_i     = {n_ch[1], n_ch[0]};
    cmp_val_i    = {n_val[1], n_val[0]};
    cmp_need_i   = {n_need[1], n_need[0]};
    conv_valid_i = v;
    conv_ch_i    = ch;
    conv_data_i  = d;
    flag_clr_i   = clr;
    for (int u = 0; u < 2; u++) begin
      logic sets;
      logic passes;
      int   need;
      need   = int'(n_need[u]) + 1;
      passes = n_ge[u] ? (d >= n_val[u]) : (d < n_val[u]);
      sets   = 1'b0;
      if (!n_en[u]) m_run[u] = 0;
      else if (v && ch == n_ch[u]) begin
        if (passes) begin
          if (m_run[u] + 1 >= need) sets = 1'b1;
          m_run[u] = (m_run[u] + 1 > need) ? need : m_run[u] + 1;
        end else m_run[u] = 0;
      end
      if (sets)        m_flag[u] = 1'b1;
      else if (clr[u]) m_flag[u] = 1'b0;
    end
    @(posedge clk_i); #1;
    conv_valid_i = 1'b0;
    flag_clr_i   = '0;
    exp_q.push_back({|(m_flag & ~n_mask), m_flag});
    tag_q.push_back(tag);
  endtask

  // monitor: compare outputs at the falling edge after each step
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({irq_o, flag_o} !== e) begin
        errors++;
        $display("FAIL %s: got irq=%b flags=%b, expected irq=%b flags=%b",
                 t, irq_o, flag_o, e[2], e[1:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_run[0] = 0; m_run[1] = 0;
    n_ch[0] = 3'd2; n_val[0] = 12'h800; n_need[0] = 4'd2;
    n_ch[1] = 3'd5; n_val[1] = 12'h100; n_need[1] = 4'd0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    checks++;
    if (flag_o !== 2'b00 || irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got irq=%b flags=%b, expected irq=0 flags=00", irq_o, flag_o);
    end
    rst_ni = 1'b1;

    // unit 0: ch 2, >= 0x800, N=3; unit 1: ch 5, < 0x100, N=1
    n_en = 2'b11; n_ge = 2'b01;
    step(1, 3'd2, 12'h800, 2'b00, "R2 equal passes with ge");
    step(1, 3'd2, 12'h900, 2'b00, "R3 two of three");
    step(1, 3'd3, 12'h000, 2'b00, "R5 foreign channel");
    step(1, 3'd2, 12'hFFF, 2'b00, "R11 flag after third pass");
    step(0, 3'd0, 12'h000, 2'b00, "R6 flag sticky");
    step(0, 3'd0, 12'h000, 2'b01, "R6 clear");
    step(1, 3'd2, 12'h850, 2'b00, "R7 resets on next pass");
    step(0, 3'd0, 12'h000, 2'b01, "R6 clear again");
    step(1, 3'd2, 12'h7FF, 2'b00, "R2 below threshold fails ge");
    step(1, 3'd2, 12'h800, 2'b00, "R4 restart 1");
    step(1, 3'd2, 12'h800, 2'b00, "R4 restart 2");
    step(1, 3'd2, 12'h800, 2'b00, "R4 restart 3 sets");
    step(1, 3'd5, 12'h100, 2'b00, "R2 equal fails lt");
    step(1, 3'd5, 12'h0FF, 2'b00, "R10 unit 1 sets alone N=1");

    n_mask = 2'b01;
    step(0, 3'd0, 12'h000, 2'b00, "R9 partial mask");
    n_mask = 2'b11;
    step(0, 3'd0, 12'h000, 2'b00, "R9 full mask");
    step(0, 3'd0, 12'h000, 2'b11, "R9 clear while masked");
    step(1, 3'd5, 12'h000, 2'b00, "R9 masked flag still sets");
    n_mask = 2'b00;
    step(1, 3'd5, 12'h000, 2'b10, "R6 set wins over clear");
    step(0, 3'd0, 12'h000, 2'b10, "R6 clear unit 1");

    // unit 0 run broken by disable
    step(1, 3'd2, 12'h000, 2'b00, "R4 fail resets");
    step(1, 3'd2, 12'hA00, 2'b00, "R8 run 1");
    step(1, 3'd2, 12'hA00, 2'b00, "R8 run 2");
    n_en = 2'b10;
    step(1, 3'd2, 12'hA00, 2'b00, "R8 disabled no set");
    n_en = 2'b11;
    step(1, 3'd2, 12'hA00, 2'b00, "R8 run restarted 1");
    step(1, 3'd2, 12'hA00, 2'b00, "R8 run restarted 2");
    step(1, 3'd2, 12'hA00, 2'b00, "R8 run restarted 3 sets");
    n_en = 2'b10;
    step(0, 3'd0, 12'h000, 2'b00, "R8 disable keeps flag");
    n_en = 2'b11;
    step(0, 3'd0, 12'h000, 2'b01, "R6 clear unit 0");

    // unit 1: ch 7, >= 0, N=16
    n_ch[1] = 3'd7; n_ge = 2'b11; n_val[1] = 12'h000; n_need[1] = 4'd15;
    step(0, 3'd0, 12'h000, 2'b00, "R3 reconfigure");
    for (int k = 1; k <= 16; k++) begin
      step(1, 3'd7, 12'(k), 2'b00, "R3 run of 16");
      if (k == 8) step(1, 3'd2, 12'h000, 2'b00, "R10 other unit fail ignored by unit 1");
    end

    repeat (3) @(posedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule